// File: doc/BRIEF.md
# Registered Two-Way Bus Transceiver

This block joins two bidirectional data buses, here called the A side and the B side. Each direction has a holding register with its own capture strobe. Each direction also has a source choice, so the driven side carries either the live value of the opposite bus or the value held in the register. The forward enable (A toward B) is active high. The reverse enable (B toward A) is active low. Each bus appears at the ports as a separate input, output and output-enable, so no tri-state logic is needed inside the block.

The capture strobes are ordinary signals, not clocks. Each one passes through an edge detector running on the common system clock, and a register loads only on a low-to-high transition of its strobe. A synchronous reset clears both registers. One combination makes the two directions feed each other with no storage in the loop: both directions enabled while both select live data. The block flags that combination with `loop_err` and turns off both output enables while it lasts.

Top module: `bidir_reg_xcvr`

## Requirements
- R1: A rising transition of `cap_fwd`, seen at a `clk` edge, loads `a_in` into the forward register. The new value is visible on `b_out` right after that edge when `sel_fwd_held` is 1.
- R2: A rising transition of `cap_rev`, seen at a `clk` edge, loads `b_in` into the reverse register. The new value is visible on `a_out` right after that edge when `sel_rev_held` is 1.
- R3: Holding a capture strobe high captures nothing further: the register keeps the value from the rising transition while its bus input changes.
- R4: `b_out` follows `a_in` combinationally when `sel_fwd_held` is 0. It shows the forward register when `sel_fwd_held` is 1.
- R5: `a_out` follows `b_in` combinationally when `sel_rev_held` is 0. It shows the reverse register when `sel_rev_held` is 1.
- R6: When `loop_err` is 0, `b_oe` equals `fwd_en` (active high).
- R7: When `loop_err` is 0, `a_oe` equals the inverse of `rev_en_n` (active low).
- R8: `loop_err` is 1 exactly when `fwd_en`=1, `rev_en_n`=0, `sel_fwd_held`=0 and `sel_rev_held`=0. While it is 1, `a_oe` and `b_oe` are both 0.
- R9: `rst` high at a `clk` edge clears both registers to zero. Capturing zeros from both buses gives the same result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| a_in | input | WIDTH | Value present on the A bus |
| a_out | output | WIDTH | Value the block drives onto the A bus |
| a_oe | output | 1 | Drive enable for the A bus |
| b_in | input | WIDTH | Value present on the B bus |
| b_out | output | WIDTH | Value the block drives onto the B bus |
| b_oe | output | 1 | Drive enable for the B bus |
| cap_fwd | input | 1 | Capture strobe for the forward (A) register |
| cap_rev | input | 1 | Capture strobe for the reverse (B) register |
| fwd_en | input | 1 | Enables driving the B bus, active high |
| rev_en_n | input | 1 | Enables driving the A bus, active low |
| sel_fwd_held | input | 1 | 1 drives the forward register onto B, 0 drives live A |
| sel_rev_held | input | 1 | 1 drives the reverse register onto A, 0 drives live B |
| loop_err | output | 1 | Illegal loop configuration present |

## Verification
The bench builds the block with WIDTH=4 and no strobe synchronizer stages. At that width the bench can sweep every combination of the four control inputs against every pair of 4-bit bus values. The live paths, the held paths, the enables and the loop flag are therefore all checked in full, not sampled. Capture checks use values whose bits differ so that every bit position is seen to load. A held-high strobe checks that no repeated load happens. Reset is checked against a register that holds a nonzero value.

// File: rtl/xcvr_pkg.sv
package xcvr_pkg;

   typedef enum logic {
      SRC_LIVE = 1'b0,
      SRC_HELD = 1'b1
   } src_e;

   function automatic logic loop_hazard(input logic fwd_on, input logic rev_on,
                                        input src_e fwd_src, input src_e rev_src);
      return fwd_on && rev_on && (fwd_src == SRC_LIVE) && (rev_src == SRC_LIVE);
   endfunction

endpackage

// File: rtl/xcvr_edge.sv
module xcvr_edge #(
   parameter int SYNC_STAGES = 0
) (
   input  logic clk,
   input  logic rst,
   input  logic strobe,
   output logic rise
);
   localparam int MAX_STAGES = 3;

   logic seen;
   logic last;

   generate
      if (SYNC_STAGES < 0 || SYNC_STAGES > MAX_STAGES) begin : g_bad_stages
         $error("xcvr_edge: SYNC_STAGES out of range");
      end
      if (SYNC_STAGES == 0) begin : g_direct
         assign seen = strobe;
      end else begin : g_sync
         logic [SYNC_STAGES-1:0] chain;
         always_ff @(posedge clk) begin
            if (rst) chain <= '0;
            else     chain <= {chain[SYNC_STAGES-2 >= 0 ? SYNC_STAGES-2 : 0:0], strobe} & {SYNC_STAGES{1'b1}};
         end
         assign seen = chain[SYNC_STAGES-1];
      end
   endgenerate

   always_ff @(posedge clk) begin
      if (rst) last <= 1'b0;
      else     last <= seen;
   end

   assign rise = seen && !last;

   assert_single_pulse_R3: assert property (@(posedge clk) disable iff (rst)
      rise |=> !rise);

endmodule

// File: rtl/xcvr_store.sv
module xcvr_store #(
   parameter int WIDTH = 8
) (
   input  logic             clk,
   input  logic             rst,
   input  logic             load,
   input  logic [WIDTH-1:0] d,
   output logic [WIDTH-1:0] q
);
   generate
      if (WIDTH < 1) begin : g_bad_width
         $error("xcvr_store: WIDTH must be positive");
      end
   endgenerate

   always_ff @(posedge clk) begin
      if (rst)       q <= '0;
      else if (load) q <= d;
   end

   assert_capture_R1: assert property (@(posedge clk) disable iff (rst)
      load |=> q == $past(d));
   assert_hold_R3: assert property (@(posedge clk) disable iff (rst)
      !load |=> $stable(q));

endmodule

// File: rtl/xcvr_path.sv
module xcvr_path
   import xcvr_pkg::*;
#(
   parameter int WIDTH = 8
) (
   input  logic             sel_held,
   input  logic [WIDTH-1:0] live,
   input  logic [WIDTH-1:0] held,
   output logic [WIDTH-1:0] y
);
   src_e src;
   assign src = src_e'(sel_held);

   always_comb begin
      unique case (src)
         SRC_HELD: y = held;
         default:  y = live;
      endcase
   end
endmodule

// File: rtl/xcvr_guard.sv
module xcvr_guard
   import xcvr_pkg::*;
(
   input  logic clk,
   input  logic rst,
   input  logic fwd_en,
   input  logic rev_en_n,
   input  logic sel_fwd_held,
   input  logic sel_rev_held,
   output logic fwd_oe,
   output logic rev_oe,
   output logic err
);
   assign err    = loop_hazard(fwd_en, !rev_en_n, src_e'(sel_fwd_held), src_e'(sel_rev_held));
   assign fwd_oe = fwd_en && !err;
   assign rev_oe = !rev_en_n && !err;

   assert_err_blocks_drive_R8: assert property (@(posedge clk) disable iff (rst)
      err |-> (!fwd_oe && !rev_oe));
   assert_never_both_live_R8: assert property (@(posedge clk) disable iff (rst)
      (fwd_oe && rev_oe) |-> (sel_fwd_held || sel_rev_held));

endmodule

// File: rtl/bidir_reg_xcvr.sv
module bidir_reg_xcvr #(
   parameter int WIDTH       = 8,
   parameter int SYNC_STAGES = 0
) (
   input  logic             clk,
   input  logic             rst,
   input  logic [WIDTH-1:0] a_in,
   output logic [WIDTH-1:0] a_out,
   output logic             a_oe,
   input  logic [WIDTH-1:0] b_in,
   output logic [WIDTH-1:0] b_out,
   output logic             b_oe,
   input  logic             cap_fwd,
   input  logic             cap_rev,
   input  logic             fwd_en,
   input  logic             rev_en_n,
   input  logic             sel_fwd_held,
   input  logic             sel_rev_held,
   output logic             loop_err
);
   localparam int NDIR = 2;
   localparam int FWD  = 0;
   localparam int REV  = 1;

   logic [NDIR-1:0]            strobe;
   logic [NDIR-1:0]            rise;
   logic [NDIR-1:0]            sel;
   logic [NDIR-1:0][WIDTH-1:0] src_bus;
   logic [NDIR-1:0][WIDTH-1:0] held;
   logic [NDIR-1:0][WIDTH-1:0] drv;

   assign strobe  = {cap_rev, cap_fwd};
   assign sel     = {sel_rev_held, sel_fwd_held};
   assign src_bus[FWD] = a_in;
   assign src_bus[REV] = b_in;

   generate
      for (genvar g = 0; g < NDIR; g++) begin : g_dir
         xcvr_edge #(.SYNC_STAGES(SYNC_STAGES)) u_edge (
            .clk(clk), .rst(rst), .strobe(strobe[g]), .rise(rise[g]));
         xcvr_store #(.WIDTH(WIDTH)) u_store (
            .clk(clk), .rst(rst), .load(rise[g]), .d(src_bus[g]), .q(held[g]));
         xcvr_path #(.WIDTH(WIDTH)) u_path (
            .sel_held(sel[g]), .live(src_bus[g]), .held(held[g]), .y(drv[g]));
      end
   endgenerate

   assign b_out = drv[FWD];
   assign a_out = drv[REV];

   xcvr_guard u_guard (
      .clk(clk), .rst(rst),
      .fwd_en(fwd_en), .rev_en_n(rev_en_n),
      .sel_fwd_held(sel_fwd_held), .sel_rev_held(sel_rev_held),
      .fwd_oe(b_oe), .rev_oe(a_oe), .err(loop_err));

   assert_held_out_stable_R1: assert property (@(posedge clk) disable iff (rst)
      (!$past(rst) && !$past(rise[FWD]) && sel_fwd_held && $past(sel_fwd_held))
         |-> $stable(b_out));
   assert_held_out_stable_R2: assert property (@(posedge clk) disable iff (rst)
      (!$past(rst) && !$past(rise[REV]) && sel_rev_held && $past(sel_rev_held))
         |-> $stable(a_out));

endmodule

// File: tb/sim_bidir_reg_xcvr.sv
`timescale 1ns/1ps
module sim_bidir_reg_xcvr;
   localparam int W = 4;

   logic         clk = 1'b0;
   logic         rst;
   logic [W-1:0] a_in, b_in, a_out, b_out;
   logic         a_oe, b_oe, loop_err;
   logic         cap_fwd, cap_rev, fwd_en, rev_en_n, sel_fwd_held, sel_rev_held;

   int total = 0;
   int bad   = 0;
   logic [W-1:0] m_fwd, m_rev;

   always #4 clk = ~clk;

   bidir_reg_xcvr #(.WIDTH(W), .SYNC_STAGES(0)) u0 (
      .clk(clk), .rst(rst),
      .a_in(a_in), .a_out(a_out), .a_oe(a_oe),
      .b_in(b_in), .b_out(b_out), .b_oe(b_oe),
      .cap_fwd(cap_fwd), .cap_rev(cap_rev),
      .fwd_en(fwd_en), .rev_en_n(rev_en_n),
      .sel_fwd_held(sel_fwd_held), .sel_rev_held(sel_rev_held),
      .loop_err(loop_err));

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      total++;
      if (act !== exp) begin
         bad++;
         $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
      end
   endtask

   task automatic pulse_fwd(input logic [W-1:0] v);
      @(negedge clk); a_in = v; cap_fwd = 1'b1;
      @(negedge clk); cap_fwd = 1'b0;
      m_fwd = v;
   endtask

   task automatic pulse_rev(input logic [W-1:0] v);
      @(negedge clk); b_in = v; cap_rev = 1'b1;
      @(negedge clk); cap_rev = 1'b0;
      m_rev = v;
   endtask

   initial begin
      #200000;
      bad++; total++;
      $display("FAIL watchdog expired actual=running expected=done");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      rst = 1'b1; a_in = '0; b_in = '0; cap_fwd = 0; cap_rev = 0;
      fwd_en = 0; rev_en_n = 1; sel_fwd_held = 1; sel_rev_held = 1;
      m_fwd = '0; m_rev = '0;
      repeat (3) @(negedge clk);
      rst = 1'b0;
      @(negedge clk);
      // R9: reset state of both registers
      chk("R9 reset fwd reg", b_out, 0);
      chk("R9 reset rev reg", a_out, 0);
      chk("R6 reset b_oe", b_oe, 0);
      chk("R7 reset a_oe", a_oe, 0);

      // R1 / R2: captures with varied patterns
      pulse_fwd(4'hA); chk("R1 capture A", b_out, 4'hA);
      pulse_fwd(4'h5); chk("R1 capture 5", b_out, 4'h5);
      pulse_rev(4'h3); chk("R2 capture 3", a_out, 4'h3);
      pulse_rev(4'hC); chk("R2 capture C", a_out, 4'hC);

      // R3: strobe held high, bus changes, no reload
      @(negedge clk); a_in = 4'h9; cap_fwd = 1'b1;
      @(negedge clk); a_in = 4'h6;
      repeat (3) @(negedge clk);
      chk("R3 fwd held strobe", b_out, 4'h9);
      cap_fwd = 1'b0; m_fwd = 4'h9;
      @(negedge clk); b_in = 4'hE; cap_rev = 1'b1;
      @(negedge clk); b_in = 4'h1;
      repeat (3) @(negedge clk);
      chk("R3 rev held strobe", a_out, 4'hE);
      cap_rev = 1'b0; m_rev = 4'hE;
      @(negedge clk);

      // R4..R8: full sweep of controls and bus values
      for (int c = 0; c < 16; c++) begin
         for (int a = 0; a < 16; a++) begin
            for (int b = 0; b < 16; b++) begin
               logic lp;
               fwd_en = c[3]; rev_en_n = c[2]; sel_fwd_held = c[1]; sel_rev_held = c[0];
               a_in = W'(a); b_in = W'(b);
               #1;
               lp = c[3] && !c[2] && !c[1] && !c[0];
               chk("R4 b_out", b_out, c[1] ? m_fwd : W'(a));
               chk("R5 a_out", a_out, c[0] ? m_rev : W'(b));
               if (a == 0 && b == 0) begin
                  chk("R8 loop_err", loop_err, lp);
                  chk("R6 b_oe", b_oe, c[3] && !lp);
                  chk("R7 a_oe", a_oe, !c[2] && !lp);
               end
            end
         end
      end
      fwd_en = 0; rev_en_n = 1; sel_fwd_held = 1; sel_rev_held = 1;

      // R9: reset clears nonzero registers
      @(negedge clk); rst = 1'b1;
      @(negedge clk); rst = 1'b0;
      chk("R9 reset clears fwd", b_out, 0);
      chk("R9 reset clears rev", a_out, 0);

      // R9: both strobes with zero buses load zeros
      pulse_fwd(4'hF); pulse_rev(4'hF);
      @(negedge clk); a_in = '0; b_in = '0; cap_fwd = 1; cap_rev = 1;
      @(negedge clk); cap_fwd = 0; cap_rev = 0;
      chk("R9 zero load fwd", b_out, 0);
      chk("R9 zero load rev", a_out, 0);

      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end
endmodule